// File: doc/BRIEF.md
# Transport Stream Byte-to-Word Packer

This block sits between the byte-wide parallel output of a video/audio encoder and a 32-bit processor-side buffer. It is clocked by the encoder's output port clock, which runs at 9 MHz or 6.75 MHz. On each edge where the data-valid strobe is high, it considers one byte. A selection input decides whether that byte belongs to a wanted stream, based on the byte's audio/video flag. Accepted bytes are gathered four at a time into a 32-bit word, which is written out with a one-cycle strobe.

Word packing is locked to transport packet starts. A byte that carries the packet-start flag always opens a new word and a new packet. The block counts whole words inside each 188-byte packet, which is 47 words, and marks the last word of every packet with a pulse. If a packet start arrives while a word is only partly filled, the partial bytes are dropped. A sticky error flag then records the slip.

Top module: `ts_word_packer`

## Requirements
- R1: A synchronous active-high reset clears `word_wr`, `pkt_done` and `align_err`. The first accepted byte after reset lands in bits 31:24.
- R2: Four accepted bytes form one word. The earliest of the four is in bits 31:24 and the latest in bits 7:0. `word_wr` is high for exactly one cycle, namely the cycle after the clock edge that accepted the fourth byte, and `word_out` holds the word in that cycle.
- R3: A byte is considered only on a rising edge where `byte_vld` is 1. On other edges the data, flags and sync input have no effect.
- R4: `is_audio` = 1 marks an audio byte and 0 a video byte. The `av_sel` input selects which bytes are accepted:
  - 2'b00 accepts video only.
  - 2'b01 accepts audio only.
  - 2'b10 and 2'b11 accept both.
  A rejected byte, including one carrying `pkt_start`, leaves the byte lane, the word count and the partial word unchanged.
- R5: An accepted byte with `pkt_start` = 1 goes into bits 31:24 and restarts the word count of the packet at zero.
- R6: An accepted byte with `pkt_start` = 1 that arrives when one to three bytes of a word are pending has two effects. The pending bytes are discarded and produce no word. `align_err` rises on the next cycle and stays high until reset.
- R7: `pkt_done` pulses in the same cycle as the `word_wr` of the 47th word counted from a packet start, that is, after 188 accepted bytes. The count then wraps to zero, so a stream without further packet-start flags gets a pulse every 47 words.
- R8: A packet start that arrives on a word boundary does not set `align_err`. It still restarts the word count, even if the previous packet was shorter than 47 words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Encoder output port clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_in | input | 8 | Stream byte |
| byte_vld | input | 1 | Byte valid strobe |
| is_audio | input | 1 | 1 = audio byte, 0 = video byte |
| pkt_start | input | 1 | Byte is the first of a transport packet |
| av_sel | input | 2 | Stream selection: 00 video, 01 audio, 1x both |
| word_out | output | 32 | Packed word, big-endian byte order |
| word_wr | output | 1 | One-cycle write strobe for `word_out` |
| pkt_done | output | 1 | Pulses with the write of a packet's last word |
| align_err | output | 1 | Sticky flag: partial word lost at a packet start |

## Verification
The bench goes after several corner cases:
- Packet-start flags on cycles where `byte_vld` is low. A design that honoured them would realign, shifting every later word and setting the error flag.
- Start flags on rejected-stream bytes. A filter applied only to the data, and not to the counters, would corrupt the lane count.
- A start that cuts a word after two bytes. The first word after it must begin with the start byte, and `align_err` must stick.
- A short packet followed by a boundary-aligned start. It proves that the word count restarts without a false error, and that `pkt_done` does not fire early or late.
- A long run without starts. It checks the 47-word wrap, and an off-by-one counter would drift its pulse.

// File: rtl/ts_pack_pkg.sv
package ts_pack_pkg;

  typedef enum logic [1:0] {
    SEL_VIDEO = 2'b00,
    SEL_AUDIO = 2'b01,
    SEL_BOTH  = 2'b10,
    SEL_ANY   = 2'b11
  } av_sel_e;

  // Stream filter decision for one byte.
  function automatic logic byte_wanted(input logic [1:0] sel, input logic audio);
    case (av_sel_e'(sel))
      SEL_VIDEO: byte_wanted = !audio;
      SEL_AUDIO: byte_wanted = audio;
      default:   byte_wanted = 1'b1;
    endcase
  endfunction

  // Modulo increment.
  function automatic int next_mod(input int v, input int m);
    next_mod = (v + 1 >= m) ? 0 : v + 1;
  endfunction

  // MSB of the slot that lane g occupies; lane 0 is the most significant.
  function automatic int lane_hi(input int g, input int lanes, input int bw);
    lane_hi = (lanes - g) * bw - 1;
  endfunction

endpackage

// File: rtl/ts_byte_filter.sv
module ts_byte_filter (
  input  logic       byte_vld,
  input  logic       is_audio,
  input  logic [1:0] av_sel,
  output logic       take
);
  always_comb take = byte_vld && ts_pack_pkg::byte_wanted(av_sel, is_audio);
endmodule

// File: rtl/ts_lane_ctr.sv
module ts_lane_ctr #(
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take,
  input  logic                     sync,
  output logic [$clog2(LANES)-1:0] lane_q,
  output logic [$clog2(LANES)-1:0] cur_lane,
  output logic                     word_full,
  output logic                     drop_partial
);
  localparam int LW = $clog2(LANES);

  always_comb begin
    cur_lane     = sync ? '0 : lane_q;
    word_full    = take && (cur_lane == LW'(LANES - 1));
    drop_partial = take && sync && (lane_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) lane_q <= '0;
    else if (take) lane_q <= LW'(ts_pack_pkg::next_mod(int'(cur_lane), LANES));
  end
endmodule

// File: rtl/ts_word_assembler.sv
module ts_word_assembler #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take,
  input  logic [$clog2(LANES)-1:0] cur_lane,
  input  logic                     word_full,
  input  logic [BYTE_W-1:0]        byte_in,
  output logic [LANES*BYTE_W-1:0]  word_out,
  output logic                     word_wr
);
  localparam int LW = $clog2(LANES);
  localparam int WW = LANES * BYTE_W;

  logic [WW-1:0] stage_q;
  logic [WW-1:0] merged;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HI = ts_pack_pkg::lane_hi(g, LANES, BYTE_W);
    assign merged[HI -: BYTE_W] = (take && cur_lane == LW'(g)) ? byte_in : stage_q[HI -: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      word_out <= '0;
      word_wr  <= 1'b0;
    end else begin
      word_wr <= word_full;
      if (take) stage_q <= merged;
      if (word_full) word_out <= merged;
    end
  end
endmodule

// File: rtl/ts_pkt_word_ctr.sv
module ts_pkt_word_ctr #(
  parameter int WORDS = 47
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     word_full,
  input  logic                     sync_take,
  output logic [$clog2(WORDS)-1:0] idx_q,
  output logic                     pkt_end,
  output logic                     done_q
);
  localparam int IW = $clog2(WORDS);

  logic [IW-1:0] cur_idx;

  always_comb begin
    cur_idx = sync_take ? '0 : idx_q;
    pkt_end = word_full && (cur_idx == IW'(WORDS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= pkt_end;
      if (word_full) idx_q <= IW'(ts_pack_pkg::next_mod(int'(cur_idx), WORDS));
      else if (sync_take) idx_q <= '0;
    end
  end
endmodule

// File: rtl/ts_word_packer.sv
module ts_word_packer #(
  parameter int BYTE_W    = 8,
  parameter int LANES     = 4,
  parameter int PKT_BYTES = 188
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [BYTE_W-1:0]       byte_in,
  input  logic                    byte_vld,
  input  logic                    is_audio,
  input  logic                    pkt_start,
  input  logic [1:0]              av_sel,
  output logic [LANES*BYTE_W-1:0] word_out,
  output logic                    word_wr,
  output logic                    pkt_done,
  output logic                    align_err
);
  localparam int WORDS_PER_PKT = PKT_BYTES / LANES;
  localparam int LW = $clog2(LANES);
  localparam int IW = $clog2(WORDS_PER_PKT);

  // Named internal events, visible to the bound checker.
  logic          take_w;
  logic          sync_take_w;
  logic          word_full_w;
  logic          drop_w;
  logic          pkt_end_w;
  logic [LW-1:0] lane_q_w;
  logic [LW-1:0] cur_lane_w;
  logic [IW-1:0] word_idx_w;

  ts_byte_filter u_filt (
    .byte_vld (byte_vld),
    .is_audio (is_audio),
    .av_sel   (av_sel),
    .take     (take_w)
  );

  assign sync_take_w = take_w && pkt_start;

  ts_lane_ctr #(.LANES(LANES)) u_lane (
    .clk          (clk),
    .rst          (rst),
    .take         (take_w),
    .sync         (pkt_start),
    .lane_q       (lane_q_w),
    .cur_lane     (cur_lane_w),
    .word_full    (word_full_w),
    .drop_partial (drop_w)
  );

  ts_word_assembler #(.BYTE_W(BYTE_W), .LANES(LANES)) u_asm (
    .clk       (clk),
    .rst       (rst),
    .take      (take_w),
    .cur_lane  (cur_lane_w),
    .word_full (word_full_w),
    .byte_in   (byte_in),
    .word_out  (word_out),
    .word_wr   (word_wr)
  );

  ts_pkt_word_ctr #(.WORDS(WORDS_PER_PKT)) u_wctr (
    .clk       (clk),
    .rst       (rst),
    .word_full (word_full_w),
    .sync_take (sync_take_w),
    .idx_q     (word_idx_w),
    .pkt_end   (pkt_end_w),
    .done_q    (pkt_done)
  );

  always_ff @(posedge clk) begin
    if (rst) align_err <= 1'b0;
    else if (drop_w) align_err <= 1'b1;
  end
endmodule

// File: rtl/ts_word_packer_chk.sv
module ts_word_packer_chk #(
  parameter int LANES = 4,
  parameter int WORDS = 47
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     byte_vld,
  input logic                     pkt_start,
  input logic                     accepted,
  input logic [$clog2(LANES)-1:0] lane_q,
  input logic [$clog2(WORDS)-1:0] word_idx,
  input logic                     word_wr,
  input logic                     pkt_done,
  input logic                     align_err
);
  localparam int LW = $clog2(LANES);
  localparam int IW = $clog2(WORDS);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!word_wr && !pkt_done && !align_err && lane_q == '0));

  // R2
  word_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    word_wr |-> lane_q == '0);

  // R3
  no_word_without_byte_chk: assert property (@(posedge clk) disable iff (rst)
    !byte_vld |=> !word_wr);

  // R4
  reject_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
    !accepted |=> ($stable(lane_q) && $stable(word_idx)));

  // R5
  sync_restarts_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (accepted && pkt_start) |=> lane_q == LW'(1 % LANES));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    align_err |=> align_err);

  // R7
  done_with_word_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> word_wr);

  // R7
  idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    word_idx <= IW'(WORDS - 1));
endmodule

bind ts_word_packer ts_word_packer_chk #(.LANES(LANES), .WORDS(WORDS_PER_PKT)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .byte_vld  (byte_vld),
  .pkt_start (pkt_start),
  .accepted  (take_w),
  .lane_q    (lane_q_w),
  .word_idx  (word_idx_w),
  .word_wr   (word_wr),
  .pkt_done  (pkt_done),
  .align_err (align_err)
);

// File: tb/ts_word_packer_tb_top.sv
module ts_word_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  byte_in = '0;
  logic        byte_vld = 1'b0;
  logic        is_audio = 1'b0;
  logic        pkt_start = 1'b0;
  logic [1:0]  av_sel = 2'b00;
  logic [31:0] word_out;
  logic        word_wr;
  logic        pkt_done;
  logic        align_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int dut_words = 0;
  int dut_dones = 0;
  logic [31:0] last_word = '0;

  // Reference model state.
  logic [7:0]  q[$];
  int          wcnt = 0;
  logic        exp_wr = 0, exp_done = 0, exp_err = 0;
  logic [31:0] exp_word = '0;

  always #2.5 clk = ~clk;

  ts_word_packer dut_i (
    .clk(clk), .rst(rst), .byte_in(byte_in), .byte_vld(byte_vld),
    .is_audio(is_audio), .pkt_start(pkt_start), .av_sel(av_sel),
    .word_out(word_out), .word_wr(word_wr), .pkt_done(pkt_done),
    .align_err(align_err)
  );

  function automatic bit wanted(input logic [1:0] sel, input logic a);
    if (sel == 2'd0) return !a;
    if (sel == 2'd1) return a;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference, updated at each rising edge.
  always @(posedge clk) begin
    cyc++;
    exp_wr = 0;
    exp_done = 0;
    if (rst) begin
      q.delete();
      wcnt = 0;
      exp_err = 0;
    end else if (byte_vld && wanted(av_sel, is_audio)) begin
      if (pkt_start) begin
        if (q.size() != 0) exp_err = 1;
        q.delete();
        wcnt = 0;
      end
      q.push_back(byte_in);
      if (q.size() == 4) begin
        exp_word = {q[0], q[1], q[2], q[3]};
        exp_wr = 1;
        wcnt++;
        if (wcnt == 47) begin
          exp_done = 1;
          wcnt = 0;
        end
        q.delete();
      end
    end
  end

  // Compare on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      chk("R2 word_wr", {31'd0, word_wr}, {31'd0, exp_wr});
      if (exp_wr) chk("R2 word_out", word_out, exp_word);
      chk("R7 pkt_done", {31'd0, pkt_done}, {31'd0, exp_done});
      chk("R6 align_err", {31'd0, align_err}, {31'd0, exp_err});
    end
    if (word_wr) begin
      dut_words++;
      last_word = word_out;
    end
    if (pkt_done) dut_dones++;
  end

  always @(posedge clk) begin
    if (cyc > 60000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic put(input bit v, input logic [7:0] d, input bit a, input bit s);
    @(negedge clk);
    byte_vld = v;
    byte_in = d;
    is_audio = a;
    pkt_start = s;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) put(0, 8'h00, 0, 0);
  endtask

  task automatic clear_counts();
    @(negedge clk);
    dut_words = 0;
    dut_dones = 0;
  endtask

  // Bytes in n counted from the start; gaps and opposite-stream noise optional.
  task automatic send(input int n, input bit a, input int base, input bit first_sync,
                      input bit gaps, input bit noise);
    for (int i = 0; i < n; i++) begin
      put(1, 8'(base + i * 7), a, first_sync && i == 0);
      if (gaps && (i % 5 == 4)) put(0, 8'hA5, a, 1);
      if (noise && (i % 9 == 3)) put(1, 8'h5A, !a, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 word_wr", {31'd0, word_wr}, 32'd0);
    chk("R1 pkt_done", {31'd0, pkt_done}, 32'd0);
    chk("R1 align_err", {31'd0, align_err}, 32'd0);
    rst = 0;

    // Video only, with invalid cycles and rejected audio bytes carrying sync.
    av_sel = 2'b00;
    clear_counts();
    send(188, 0, 16, 1, 1, 1);
    idle(3);
    chk("R3 words despite invalid sync", dut_words, 47);
    chk("R4 video-only words", dut_words, 47);
    chk("R7 one packet done", dut_dones, 1);
    chk("R2 last word bytes", last_word,
        {8'(16 + 184 * 7), 8'(16 + 185 * 7), 8'(16 + 186 * 7), 8'(16 + 187 * 7)});

    // Audio only.
    av_sel = 2'b01;
    clear_counts();
    send(188, 1, 3, 1, 0, 1);
    idle(3);
    chk("R4 audio-only words", dut_words, 47);
    chk("R7 audio packet done", dut_dones, 1);

    // Both streams, mixed flags.
    av_sel = 2'b10;
    clear_counts();
    for (int i = 0; i < 188; i++) put(1, 8'(i), 1'(i % 3 == 0), i == 0);
    idle(3);
    chk("R4 both-stream words", dut_words, 47);

    // Misaligned start: two pending bytes then a new packet.
    clear_counts();
    put(1, 8'h11, 0, 1);
    put(1, 8'h22, 0, 0);
    put(1, 8'hC1, 0, 1);
    put(1, 8'hC2, 0, 0);
    put(1, 8'hC3, 1, 0);
    put(1, 8'hC4, 0, 0);
    idle(2);
    chk("R5 first word after start", last_word, 32'hC1C2C3C4);
    chk("R6 error raised", {31'd0, align_err}, 32'd1);
    chk("R6 partial dropped", dut_words, 1);
    send(184, 0, 9, 0, 1, 0);
    idle(5);
    chk("R6 error sticky", {31'd0, align_err}, 32'd1);
    chk("R5 done after restart", dut_dones, 1);

    // Reset, short packet, then a start on a word boundary.
    rst = 1;
    idle(2);
    rst = 0;
    chk("R1 error cleared", {31'd0, align_err}, 32'd0);
    clear_counts();
    send(100, 0, 40, 1, 0, 0);
    send(188, 0, 77, 1, 1, 0);
    idle(3);
    chk("R8 no error at boundary start", {31'd0, align_err}, 32'd0);
    chk("R8 words", dut_words, 72);
    chk("R8 only full packet done", dut_dones, 1);

    // Continuous stream without start flags: count wraps.
    av_sel = 2'b11;
    clear_counts();
    send(376, 1, 5, 0, 1, 0);
    idle(3);
    chk("R7 wrap words", dut_words, 94);
    chk("R7 wrap dones", dut_dones, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule